// File: doc/BRIEF.md
# Synchronous Serial Shift Port

This block moves one byte at a time over a three-wire synchronous link made of a serial clock, a serial data output and a serial data input. Software picks clock master or clock slave with a register bit. No pin selects the mode and no pin frames a transfer. In master mode the port makes the serial clock from the system clock, with a programmable half-period. In slave mode it follows an external serial clock, which it brings into the system clock domain through a two-flop synchronizer before it detects edges.

A second bit sets only the level the serial clock rests at between transfers. Whatever that level, the port changes outgoing data on falling serial-clock edges and captures incoming data on rising edges, most significant bit first. A single shift register serves as both the transmit buffer and the receive buffer. A transfer ends on the eighth rising edge that follows a falling edge. The port then raises a done flag, and the received byte can be read.

Top module: `sync_shift_port`

## Requirements
- R1: While reset is active and just after it is released, `busy` and `done` are 0, `sdo` is 0, and `sck_out` is 1.
- R2: In master mode with no transfer running, `sck_out` rests at 1 when `cfg_idle_low`=0 and at 0 when `cfg_idle_low`=1. `sck_oe` equals `cfg_master`.
- R3: In master mode each serial-clock half-period lasts H system clocks, where H = `div_val`, or 1 when `div_val` is 0. `done` rises exactly 16·H clock edges after the edge that accepts `start`.
- R4: With idle-high, a master transfer makes exactly 8 falling and 8 rising edges on `sck_out`, and `busy` drops together with `done`. With idle-low, the master first drives the clock high, then makes 8 falling and 8 rising data edges, then spends one more half-period before it returns low. That gives 9 edges of each kind, and `busy` stays high for H more cycles after `done`.
- R5: `sdo` changes only at falling serial-clock edges. At the k-th falling edge of a transfer it presents bit (8−k) of the byte written with `start`, so the most significant bit goes first.
- R6: `sdi` is captured on rising edges only, each one after a falling edge, and is shifted in at the low end. After `done`, `rd_data` holds the eight received bits with the first bit received at bit 7.
- R7: In slave mode (`cfg_master`=0), `sck_oe` is 0. The port shifts on edges of `sck_in` seen through the synchronizer, with the same data ordering as R5 and R6, provided `sck_in` stays in each level for more than 4 system clocks.
- R8: In slave mode with idle-low, a rising edge of `sck_in` that comes before the first falling edge of a transfer captures nothing.
- R9: `done` sets on the eighth capturing rising edge. It stays set until `clr_done` is pulsed or a new transfer is accepted.
- R10: A `start` pulse while `busy` is 1 is ignored. The running transfer keeps its data and its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1: port drives the serial clock; 0: port follows `sck_in` |
| cfg_idle_low | input | 1 | 0: serial clock idles high; 1: idles low |
| div_val | input | 8 | Master half-period in system clocks (0 acts as 1) |
| start | input | 1 | One-cycle request to begin a transfer |
| wr_data | input | 8 | Byte to send, loaded when `start` is accepted |
| clr_done | input | 1 | Clears the done flag |
| rd_data | output | 8 | Shift register contents (received byte after done) |
| busy | output | 1 | Transfer or trailing clock phase in progress |
| done | output | 1 | Transfer-complete flag |
| sck_in | input | 1 | External serial clock (slave mode) |
| sck_out | output | 1 | Generated serial clock (master mode) |
| sck_oe | output | 1 | Output enable for the serial clock pad |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |

## Verification
In master mode, `sck_out` and the shift register update on the same clock edge, so `done` is due exactly 16·H edges after the edge that samples `start`. The bench counts posedges from that edge and reads `done` on the following negedge. With idle-low, `busy` must still be high on that negedge and must fall H edges later. In slave mode a serial-clock edge needs three system clocks to show up at `sdo`: two synchronizer flops and one shift-register flop. The bench therefore holds each `sck_in` level for 6 clocks, reads `sdo` just before it raises `sck_in`, and checks `done` several clocks after the last rising edge. Every sample is taken at a negedge, away from the edge where outputs change.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } ssp_edge_t;
endpackage

// File: rtl/ssp_clkgen.sv
module ssp_clkgen
  import ssp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             idle_low,
  input  logic [DIV_W-1:0] div_val,
  input  logic             go,
  output logic             sck,
  output logic             running,
  output ssp_edge_t        ev
);
  localparam int HALF_W    = $clog2(2*DATA_W+2);
  localparam int LAST_HALF = 2*DATA_W;

  logic              run_q, run_d;
  logic              sck_q, sck_d;
  logic [DIV_W-1:0]  tcnt_q, tcnt_d;
  logic [HALF_W-1:0] hcnt_q, hcnt_d;
  logic [DIV_W-1:0]  half_len;
  logic              tick;

  assign half_len = (div_val == '0) ? DIV_W'(1) : div_val;
  assign tick     = run_q && (tcnt_q == half_len - 1'b1);

  always_comb begin
    run_d  = run_q;
    sck_d  = sck_q;
    tcnt_d = tcnt_q;
    hcnt_d = hcnt_q;
    ev     = '0;
    if (!run_q) begin
      sck_d  = ~idle_low;
      tcnt_d = '0;
      hcnt_d = '0;
      if (go && en) begin
        run_d = 1'b1;
        sck_d = 1'b1;
      end
    end else if (tick) begin
      tcnt_d  = '0;
      hcnt_d  = hcnt_q + 1'b1;
      sck_d   = ~sck_q;
      ev.rise = ~sck_q;
      ev.fall = sck_q && (hcnt_q < HALF_W'(LAST_HALF));
      if ((hcnt_q + 1'b1 == HALF_W'(LAST_HALF)) && !idle_low) run_d = 1'b0;
      if (hcnt_q == HALF_W'(LAST_HALF)) run_d = 1'b0;
    end else begin
      tcnt_d = tcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      sck_q  <= 1'b1;
      tcnt_q <= '0;
      hcnt_q <= '0;
    end else begin
      run_q  <= run_d;
      sck_q  <= sck_d;
      tcnt_q <= tcnt_d;
      hcnt_q <= hcnt_d;
    end
  end

  assign sck     = sck_q;
  assign running = run_q;
endmodule

// File: rtl/ssp_sync.sv
module ssp_sync
  import ssp_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sck_in,
  input  logic      sdi_in,
  output logic      sdi_s,
  output ssp_edge_t ev
);
  logic [STAGES:0]   sck_chain;
  logic [STAGES-1:0] sdi_chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_chain <= '0;
      sdi_chain <= '0;
    end else begin
      sck_chain <= {sck_chain[STAGES-1:0], sck_in};
      sdi_chain <= {sdi_chain[STAGES-2:0], sdi_in};
    end
  end

  assign sdi_s   = sdi_chain[STAGES-1];
  assign ev.rise = sck_chain[STAGES-1] & ~sck_chain[STAGES];
  assign ev.fall = ~sck_chain[STAGES-1] & sck_chain[STAGES];
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter
  import ssp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] wr_data,
  input  ssp_edge_t         ev,
  input  logic              sdi_bit,
  input  logic              clr_done,
  output logic [DATA_W-1:0] shreg,
  output logic              sdo,
  output logic              active,
  output logic              done
);
  localparam int CNT_W = $clog2(DATA_W+1);

  logic [DATA_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              act_q, act_d;
  logic              armed_q, armed_d;
  logic              sdo_q, sdo_d;
  logic              done_q, done_d;

  always_comb begin
    sh_d    = sh_q;
    cnt_d   = cnt_q;
    act_d   = act_q;
    armed_d = armed_q;
    sdo_d   = sdo_q;
    done_d  = done_q;
    if (clr_done) done_d = 1'b0;
    if (load) begin
      sh_d    = wr_data;
      cnt_d   = '0;
      act_d   = 1'b1;
      armed_d = 1'b0;
      done_d  = 1'b0;
    end else if (act_q) begin
      if (ev.fall) begin
        sdo_d   = sh_q[DATA_W-1];
        armed_d = 1'b1;
      end
      if (ev.rise && armed_q) begin
        sh_d    = {sh_q[DATA_W-2:0], sdi_bit};
        armed_d = 1'b0;
        cnt_d   = cnt_q + 1'b1;
        if (cnt_q == CNT_W'(DATA_W-1)) begin
          act_d  = 1'b0;
          done_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      act_q   <= 1'b0;
      armed_q <= 1'b0;
      sdo_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      sh_q    <= sh_d;
      cnt_q   <= cnt_d;
      act_q   <= act_d;
      armed_q <= armed_d;
      sdo_q   <= sdo_d;
      done_q  <= done_d;
    end
  end

  assign shreg  = sh_q;
  assign sdo    = sdo_q;
  assign active = act_q;
  assign done   = done_q;
endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port
  import ssp_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_master,
  input  logic              cfg_idle_low,
  input  logic [DIV_W-1:0]  div_val,
  input  logic              start,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr_done,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              done,
  input  logic              sck_in,
  output logic              sck_out,
  output logic              sck_oe,
  input  logic              sdi,
  output logic              sdo
);
  logic [1:0] rst_pipe;
  logic       rst_ni;
  logic       go, running, active, sdi_s;
  ssp_edge_t  m_ev, s_ev, ev;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  assign busy = active | running;
  assign go   = start & ~busy;

  ssp_clkgen #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_clkgen (
    .clk(clk), .rst_n(rst_ni), .en(cfg_master), .idle_low(cfg_idle_low),
    .div_val(div_val), .go(go), .sck(sck_out), .running(running), .ev(m_ev)
  );

  ssp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_ni), .sck_in(sck_in), .sdi_in(sdi),
    .sdi_s(sdi_s), .ev(s_ev)
  );

  assign ev = cfg_master ? m_ev : s_ev;

  ssp_shifter #(.DATA_W(DATA_W)) u_shifter (
    .clk(clk), .rst_n(rst_ni), .load(go), .wr_data(wr_data), .ev(ev),
    .sdi_bit(cfg_master ? sdi : sdi_s), .clr_done(clr_done),
    .shreg(rd_data), .sdo(sdo), .active(active), .done(done)
  );

  assign sck_oe = cfg_master;
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker (
  input logic clk,
  input logic rst_n,
  input logic cfg_master,
  input logic cfg_idle_low,
  input logic start,
  input logic clr_done,
  input logic busy,
  input logic done,
  input logic sck_out,
  input logic sdo
);
  a_r9_done_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  a_r9_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr_done && !(start && !busy)) |=> done);

  a_r2_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && $past(cfg_master) && !busy && $past(!busy) && $stable(cfg_idle_low))
      |-> (sck_out == !cfg_idle_low));

  a_r5_sdo_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && $past(cfg_master) && !$stable(sdo)) |-> $fell(sck_out));

  a_r9_done_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && $past(cfg_master) && $rose(done)) |-> $rose(sck_out));
endmodule

bind sync_shift_port ssp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_idle_low(cfg_idle_low),
  .start(start), .clr_done(clr_done), .busy(busy), .done(done),
  .sck_out(sck_out), .sdo(sdo)
);

// File: tb/sim_sync_shift_port.sv
module sim_sync_shift_port;
  logic       clk, rst_n, cfg_master, cfg_idle_low, start, clr_done;
  logic [7:0] div_val, wr_data, rd_data;
  logic       busy, done, sck_in, sck_out, sck_oe, sdi, sdo;

  int n_chk = 0;
  int n_fail = 0;

  // master-mode far-end model
  logic       tb_en = 1'b0;
  logic [7:0] tb_rx = '0;
  logic [7:0] tb_cap = '0;
  int tb_rises = 0, tb_falls = 0, tb_ncap = 0, tb_idx = 0;

  sync_shift_port u0 (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_idle_low(cfg_idle_low),
    .div_val(div_val), .start(start), .wr_data(wr_data), .clr_done(clr_done),
    .rd_data(rd_data), .busy(busy), .done(done), .sck_in(sck_in),
    .sck_out(sck_out), .sck_oe(sck_oe), .sdi(sdi), .sdo(sdo)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge sck_out) if (tb_en) begin
    tb_falls = tb_falls + 1;
    if (tb_idx < 8) sdi = tb_rx[7-tb_idx];
    tb_idx = tb_idx + 1;
  end

  always @(posedge sck_out) if (tb_en) begin
    tb_rises = tb_rises + 1;
    if (tb_falls > tb_ncap && tb_ncap < 8) begin
      tb_cap  = {tb_cap[6:0], sdo};
      tb_ncap = tb_ncap + 1;
    end
  end

  function automatic int half_of(input logic [7:0] d);
    return (d == 8'd0) ? 1 : int'(d);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_master(input logic [7:0] tx, input logic [7:0] rx,
                            input logic [7:0] dv, input logic il, input bit intrude);
    int j, h, w;
    h = half_of(dv);
    @(negedge clk);
    cfg_master = 1'b1; cfg_idle_low = il; div_val = dv;
    cyc(2);
    chk("R2 idle level", sck_out, !il);
    chk("R2 oe", sck_oe, 1);
    tb_rx = rx; tb_cap = '0; tb_rises = 0; tb_falls = 0; tb_ncap = 0; tb_idx = 0;
    tb_en = 1'b1;
    wr_data = tx; start = 1'b1;
    @(posedge clk);
    j = 0;
    forever begin
      @(posedge clk);
      j++;
      @(negedge clk);
      start = 1'b0; wr_data = tx;
      if (intrude && j == 3) begin start = 1'b1; wr_data = ~tx; end
      if (done || j > 16*h + 50) break;
    end
    chk(intrude ? "R10 timing kept" : "R3 done latency", j, 16*h);
    chk("R9 done set", done, 1);
    chk("R4 busy at done", busy, il);
    chk("R6 rx byte", rd_data, rx);
    chk(intrude ? "R10 tx kept" : "R5 tx msb first", tb_cap, tx);
    w = 0;
    while (busy && w < 600) begin @(negedge clk); w++; end
    chk("R4 trailing half", il ? w : 0, il ? h : 0);
    chk("R2 idle after", sck_out, !il);
    chk("R4 rises", tb_rises, 8 + il);
    chk("R4 falls", tb_falls, 8 + il);
    tb_en = 1'b0;
  endtask

  task automatic run_slave(input logic [7:0] tx, input logic [7:0] rx, input logic il);
    logic [7:0] cap;
    cap = '0;
    @(negedge clk);
    cfg_master = 1'b0; cfg_idle_low = il; sck_in = !il;
    cyc(6);
    chk("R7 oe off", sck_oe, 0);
    wr_data = tx; start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (il) begin sck_in = 1'b1; cyc(6); end
    for (int i = 0; i < 8; i++) begin
      sck_in = 1'b0; sdi = rx[7-i];
      cyc(6);
      cap = {cap[6:0], sdo};
      sck_in = 1'b1;
      cyc(6);
    end
    if (il) sck_in = 1'b0;
    cyc(6);
    chk("R7 slave done", done, 1);
    chk("R7 slave busy", busy, 0);
    chk(il ? "R8 lead rise ignored" : "R7 slave rx", rd_data, rx);
    chk("R7 slave tx", cap, tx);
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finish");
    summary();
  end

  initial begin
    logic [7:0] a, b;
    void'($urandom(32'd4242));
    rst_n = 1'b0; cfg_master = 1'b1; cfg_idle_low = 1'b0; div_val = 8'd2;
    start = 1'b0; wr_data = '0; clr_done = 1'b0; sck_in = 1'b1; sdi = 1'b0;
    cyc(3);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 sdo", sdo, 0);
    chk("R1 sck", sck_out, 1);
    rst_n = 1'b1;
    cyc(4);
    chk("R1 after release", {busy, done, sdo, sck_out}, 4'b0001);

    // directed corners
    run_master(8'hA5, 8'h3C, 8'd0, 1'b0, 1'b0);
    run_master(8'h81, 8'h7E, 8'd1, 1'b1, 1'b0);
    cyc(20);
    chk("R9 done holds", done, 1);
    @(negedge clk); clr_done = 1'b1;
    @(negedge clk); clr_done = 1'b0;
    chk("R9 clr_done", done, 0);
    run_master(8'hFF, 8'h00, 8'd255, 1'b0, 1'b0);
    @(negedge clk); wr_data = 8'h12; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R9 start clears done", done, 0);
    while (busy) @(negedge clk);
    run_master(8'hC3, 8'h5A, 8'd3, 1'b0, 1'b1);
    run_master(8'h96, 8'hE1, 8'd2, 1'b1, 1'b1);
    run_slave(8'hB4, 8'h4B, 1'b0);
    run_slave(8'h1F, 8'hF8, 1'b1);

    // random
    for (int k = 0; k < 12; k++) begin
      a = 8'($urandom); b = 8'($urandom);
      run_master(a, b, 8'($urandom_range(0, 6)), 1'($urandom), 1'b0);
    end
    for (int k = 0; k < 4; k++) begin
      a = 8'($urandom); b = 8'($urandom);
      run_slave(a, b, 1'($urandom));
    end
    summary();
  end
endmodule